// File: doc/BRIEF.md
# Exclusive Access Rule Monitor

This block sits passively beside a pipelined single-layer bus and watches every transfer for misuse of the exclusive-access feature. It decodes the address phase (transfer type, burst kind, size, address, exclusive marker and manager tag) on the cycles where the bus accepts it. It holds what it needs of the accepted transfer until that transfer's data phase completes, so that the exclusive-okay response can be judged against the transfer it belongs to rather than against whatever address phase is on the bus at that moment.

Each rule has its own bit in a sticky violation register, which only a reset clears. A separate single-cycle pulse marks every cycle in which at least one rule was broken. Both outputs are registered, so they show a violation one clock after the bus cycle that caused it. Typical use is in simulation and emulation builds of a subsystem, or left in silicon as a debug observer, with the pulse feeding an interrupt or trace trigger.

Top module: `excl_rule_monitor`

## Requirements
- R1: An exclusive-okay response seen while the ready signal is low sets flag bit 0.
- R2: An exclusive-okay response in a completing cycle (ready high) whose data phase does not belong to an accepted exclusive NONSEQ/SEQ transfer sets flag bit 1. An empty data phase counts as non-exclusive.
- R3: An exclusive-okay response together with an error response (resp = 1) sets flag bit 2.
- R4: An accepted exclusive NONSEQ or SEQ transfer whose burst code is neither SINGLE (0) nor INCR (1) sets flag bit 3.
- R5: An accepted exclusive transfer of type SEQ (3), which makes it part of a multi-beat access, sets flag bit 4.
- R6: An accepted exclusive transfer of type BUSY (1) sets flag bit 5.
- R7: An accepted exclusive NONSEQ (2) or SEQ transfer whose address has any bit set below bit position `size` (a transfer of 2^size bytes) sets flag bit 6.
- R8: An accepted exclusive address phase that overlaps a data phase of an exclusive transfer from the same manager tag sets flag bit 7. The same overlap with a different manager tag is legal.
- R9: Address-phase rules are evaluated only in cycles with ready high. IDLE (0) transfers and cycles where the bus is stalled never raise an address-phase flag.
- R10: Flags reset to zero and stay set until reset. The pulse output is high for exactly the clock after each cycle that broke any rule, and low otherwise.
- R11: The data-phase record is loaded only when ready is high, and it holds across wait states. An exclusive-okay response given after a stall to a tracked exclusive transfer is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_trans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| bus_burst | input | 3 | Burst code: 0 SINGLE, 1 INCR, others fixed-length |
| bus_size | input | 3 | Transfer size, 2^size bytes |
| bus_addr | input | ADDR_W | Transfer address |
| bus_excl | input | 1 | Exclusive marker of the address phase |
| bus_mgr | input | MGR_W | Manager tag of the address phase |
| bus_ready | input | 1 | Transfer completion / address acceptance |
| bus_resp | input | 1 | Response, 1 = error |
| bus_exok | input | 1 | Exclusive-okay response |
| err_flags | output | 8 | Sticky per-rule violation flags |
| err_pulse | output | 1 | One-cycle marker of a violating cycle |

## Verification
The monitor is driven with a legal exclusive read that stalls and then completes with exclusive-okay. This separates correct data-phase tracking from a monitor that judges the response against the current address phase. Each rule is then broken in isolation from a fresh reset, next to a near miss: an INCR burst, a halfword on a two-byte boundary, a second manager tag overlapping an exclusive data phase, and an exclusive BUSY or misaligned phase held during a stall or marked IDLE. These show that each flag responds to its own condition and nothing broader. Repeating a violation after its flag is already set tells the sticky register apart from the pulse.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  localparam int NUM_RULES = 8;

  // flag bit positions
  localparam int RL_EXOK_STALL = 0;
  localparam int RL_EXOK_PLAIN = 1;
  localparam int RL_EXOK_ERR   = 2;
  localparam int RL_BURST      = 3;
  localparam int RL_BEAT       = 4;
  localparam int RL_BUSY       = 5;
  localparam int RL_ALIGN      = 6;
  localparam int RL_OUTSTAND   = 7;

  localparam logic [2:0] BURST_LAST_LEGAL = 3'd1;

endpackage

// File: rtl/excl_dphase_track.sv
module excl_dphase_track
  import excl_mon_pkg::*;
#(
  parameter int MGR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_trans,
  input  logic             bus_excl,
  input  logic [MGR_W-1:0] bus_mgr,
  input  logic             bus_ready,
  output logic             dph_vld,
  output logic             dph_excl,
  output logic [MGR_W-1:0] dph_mgr
);

  logic             vld_q, vld_d;
  logic             excl_q, excl_d;
  logic [MGR_W-1:0] mgr_q, mgr_d;
  logic             active;

  assign active = (bus_trans == TR_NONSEQ) || (bus_trans == TR_SEQ);

  always_comb begin
    vld_d  = vld_q;
    excl_d = excl_q;
    mgr_d  = mgr_q;
    if (bus_ready) begin
      vld_d  = active;
      excl_d = active & bus_excl;
      mgr_d  = bus_mgr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      excl_q <= 1'b0;
      mgr_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      excl_q <= excl_d;
      mgr_q  <= mgr_d;
    end
  end

  assign dph_vld  = vld_q;
  assign dph_excl = excl_q;
  assign dph_mgr  = mgr_q;

endmodule

// File: rtl/excl_addr_check.sv
module excl_addr_check
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MGR_W  = 4
) (
  input  logic [1:0]           bus_trans,
  input  logic [2:0]           bus_burst,
  input  logic [2:0]           bus_size,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_excl,
  input  logic [MGR_W-1:0]     bus_mgr,
  input  logic                 bus_ready,
  input  logic                 dph_vld,
  input  logic                 dph_excl,
  input  logic [MGR_W-1:0]     dph_mgr,
  output logic [NUM_RULES-1:0] hits
);

  // largest size code is 7, so at most 7 low address bits matter
  localparam int ALIGN_BITS = (ADDR_W < 7) ? ADDR_W : 7;

  logic accept_excl;
  logic active;
  logic misaligned;

  assign active      = (bus_trans == TR_NONSEQ) || (bus_trans == TR_SEQ);
  assign accept_excl = bus_ready & bus_excl;

  always_comb begin
    misaligned = 1'b0;
    for (int i = 0; i < ALIGN_BITS; i++) begin
      if (i < int'(bus_size)) misaligned = misaligned | bus_addr[i];
    end
  end

  always_comb begin
    hits                = '0;
    hits[RL_BURST]      = accept_excl & active & (bus_burst > BURST_LAST_LEGAL);
    hits[RL_BEAT]       = accept_excl & (bus_trans == TR_SEQ);
    hits[RL_BUSY]       = accept_excl & (bus_trans == TR_BUSY);
    hits[RL_ALIGN]      = accept_excl & active & misaligned;
    hits[RL_OUTSTAND]   = accept_excl & active & dph_vld & dph_excl &
                          (dph_mgr == bus_mgr);
  end

endmodule

// File: rtl/excl_resp_check.sv
module excl_resp_check
  import excl_mon_pkg::*;
(
  input  logic                 bus_ready,
  input  logic                 bus_resp,
  input  logic                 bus_exok,
  input  logic                 dph_vld,
  input  logic                 dph_excl,
  output logic [NUM_RULES-1:0] hits
);

  always_comb begin
    hits                = '0;
    hits[RL_EXOK_STALL] = bus_exok & ~bus_ready;
    hits[RL_EXOK_PLAIN] = bus_exok & bus_ready & ~(dph_vld & dph_excl);
    hits[RL_EXOK_ERR]   = bus_exok & bus_resp;
  end

endmodule

// File: rtl/excl_err_log.sv
module excl_err_log
  import excl_mon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RULES-1:0] hits,
  output logic [NUM_RULES-1:0] flags,
  output logic                 pulse
);

  logic [NUM_RULES-1:0] flags_q, flags_d;
  logic                 pulse_q, pulse_d;

  always_comb begin
    flags_d = flags_q | hits;
    pulse_d = |hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      pulse_q <= pulse_d;
    end
  end

  assign flags = flags_q;
  assign pulse = pulse_q;

endmodule

// File: rtl/excl_rule_monitor.sv
module excl_rule_monitor
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MGR_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bus_trans,
  input  logic [2:0]           bus_burst,
  input  logic [2:0]           bus_size,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_excl,
  input  logic [MGR_W-1:0]     bus_mgr,
  input  logic                 bus_ready,
  input  logic                 bus_resp,
  input  logic                 bus_exok,
  output logic [NUM_RULES-1:0] err_flags,
  output logic                 err_pulse
);

  logic                 rst_meta_n, rst_core_n;
  logic                 dph_vld, dph_excl;
  logic [MGR_W-1:0]     dph_mgr;
  logic [NUM_RULES-1:0] addr_hits, resp_hits, all_hits;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  excl_dphase_track #(.MGR_W(MGR_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_trans (bus_trans),
    .bus_excl  (bus_excl),
    .bus_mgr   (bus_mgr),
    .bus_ready (bus_ready),
    .dph_vld   (dph_vld),
    .dph_excl  (dph_excl),
    .dph_mgr   (dph_mgr)
  );

  excl_addr_check #(.ADDR_W(ADDR_W), .MGR_W(MGR_W)) u_addr (
    .bus_trans (bus_trans),
    .bus_burst (bus_burst),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_excl  (bus_excl),
    .bus_mgr   (bus_mgr),
    .bus_ready (bus_ready),
    .dph_vld   (dph_vld),
    .dph_excl  (dph_excl),
    .dph_mgr   (dph_mgr),
    .hits      (addr_hits)
  );

  excl_resp_check u_resp (
    .bus_ready (bus_ready),
    .bus_resp  (bus_resp),
    .bus_exok  (bus_exok),
    .dph_vld   (dph_vld),
    .dph_excl  (dph_excl),
    .hits      (resp_hits)
  );

  assign all_hits = addr_hits | resp_hits;

  excl_err_log u_log (
    .clk   (clk),
    .rst_n (rst_core_n),
    .hits  (all_hits),
    .flags (err_flags),
    .pulse (err_pulse)
  );

endmodule

// File: rtl/excl_rule_monitor_chk.sv
module excl_rule_monitor_chk
  import excl_mon_pkg::*;
(
  input logic                 clk,
  input logic                 rst_core_n,
  input logic [1:0]           bus_trans,
  input logic                 bus_excl,
  input logic                 bus_ready,
  input logic                 bus_resp,
  input logic                 bus_exok,
  input logic                 dph_excl,
  input logic [NUM_RULES-1:0] err_flags,
  input logic                 err_pulse
);

  p_exok_stall_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_exok && !bus_ready) |=> err_flags[RL_EXOK_STALL]);

  p_exok_err_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_exok && bus_resp) |=> err_flags[RL_EXOK_ERR]);

  p_excl_seq_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_ready && bus_excl && bus_trans == TR_SEQ) |=> err_flags[RL_BEAT]);

  p_excl_busy_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_ready && bus_excl && bus_trans == TR_BUSY) |=> err_flags[RL_BUSY]);

  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_pulse_has_flag_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    err_pulse |-> (err_flags != '0));

  p_track_holds_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_ready |=> $stable(dph_excl));

endmodule

bind excl_rule_monitor excl_rule_monitor_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_trans  (bus_trans),
  .bus_excl   (bus_excl),
  .bus_ready  (bus_ready),
  .bus_resp   (bus_resp),
  .bus_exok   (bus_exok),
  .dph_excl   (dph_excl),
  .err_flags  (err_flags),
  .err_pulse  (err_pulse)
);

// File: tb/excl_rule_monitor_test.sv
module excl_rule_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk;
  logic        rst_n;
  logic [1:0]  bus_trans;
  logic [2:0]  bus_burst;
  logic [2:0]  bus_size;
  logic [31:0] bus_addr;
  logic        bus_excl;
  logic [3:0]  bus_mgr;
  logic        bus_ready;
  logic        bus_resp;
  logic        bus_exok;
  logic [7:0]  err_flags;
  logic        err_pulse;

  int checks_total;
  int checks_failed;
  int cycles;

  typedef struct {
    logic [7:0] flags;
    logic       pulse;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] model_flags;

  excl_rule_monitor uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_trans (bus_trans),
    .bus_burst (bus_burst),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_excl  (bus_excl),
    .bus_mgr   (bus_mgr),
    .bus_ready (bus_ready),
    .bus_resp  (bus_resp),
    .bus_exok  (bus_exok),
    .err_flags (err_flags),
    .err_pulse (err_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compare registered outputs just after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks_total++;
      if (err_flags !== e.flags || err_pulse !== e.pulse) begin
        checks_failed++;
        $display("FAIL %s: flags=%h pulse=%b expected flags=%h pulse=%b",
                 e.tag, err_flags, err_pulse, e.flags, e.pulse);
      end
    end
  end

  task automatic bus_quiet();
    bus_trans = 2'd0; bus_burst = 3'd0; bus_size = 3'd2; bus_addr = '0;
    bus_excl = 1'b0; bus_mgr = '0; bus_ready = 1'b1; bus_resp = 1'b0;
    bus_exok = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_quiet();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_flags = '0;
    checks_total++;
    if (err_flags !== 8'h00 || err_pulse !== 1'b0) begin
      checks_failed++;
      $display("FAIL R10 reset: flags=%h pulse=%b expected flags=00 pulse=0",
               err_flags, err_pulse);
    end
  endtask

  // driver: one bus cycle plus the rule bits it is expected to break
  task automatic step(input string tag, input logic [1:0] t, input logic [2:0] b,
                      input logic [2:0] s, input logic [31:0] a, input logic x,
                      input logic [3:0] m, input logic rdy, input logic rsp,
                      input logic ok, input logic [7:0] hits);
    exp_t e;
    @(negedge clk);
    bus_trans = t; bus_burst = b; bus_size = s; bus_addr = a;
    bus_excl = x; bus_mgr = m; bus_ready = rdy; bus_resp = rsp; bus_exok = ok;
    model_flags = model_flags | hits;
    e.flags = model_flags;
    e.pulse = |hits;
    e.tag   = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, 2'd0, 3'd0, 3'd2, 32'h0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic drain();
    @(negedge clk);
    bus_quiet();
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks_total++;
        checks_failed++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
        $display("%0d/%0d checks passed", checks_total - checks_failed, checks_total);
        $finish;
      end
    end
  end

  initial begin
    checks_total = 0; checks_failed = 0; model_flags = '0;
    rst_n = 1'b0;
    bus_quiet();

    // R11: legal exclusive read, stalled, then exclusive-okay
    do_reset();
    step("R11 excl accept",  2'd2, 3'd0, 3'd2, 32'h100, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R11 stall",        2'd0, 3'd0, 3'd2, 32'h0,   1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 8'h00);
    step("R11 exok legal",   2'd0, 3'd0, 3'd2, 32'h0,   1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'h00);
    // R2: exok on a plain transfer
    step("R2 plain accept",  2'd2, 3'd0, 3'd2, 32'h200, 1'b0, 4'd1, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R2 exok on plain", 2'd0, 3'd0, 3'd2, 32'h0,   1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'h02);
    // R10: flag stays, pulse drops
    idle("R10 sticky hold");
    // R1: exok while stalled
    step("R1 exok stalled",  2'd0, 3'd0, 3'd2, 32'h0,   1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 8'h01);
    drain();

    // R3: exok together with error
    do_reset();
    step("R3 excl accept",   2'd2, 3'd0, 3'd2, 32'h100, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R3 exok+error",    2'd0, 3'd0, 3'd2, 32'h0,   1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 8'h04);
    drain();

    // R4 / R5: burst kind and beat count
    do_reset();
    step("R4 INCR legal",    2'd2, 3'd1, 3'd2, 32'h100, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h00);
    idle("R4 gap");
    step("R4 INCR4 illegal", 2'd2, 3'd3, 3'd2, 32'h100, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h08);
    idle("R5 gap");
    step("R5 SEQ excl",      2'd3, 3'd1, 3'd2, 32'h104, 1'b1, 4'd2, 1'b1, 1'b0, 1'b0, 8'h10);
    drain();

    // R9 then R6: stalled / IDLE cycles ignored, accepted BUSY flagged
    do_reset();
    step("R9 BUSY stalled",  2'd1, 3'd1, 3'd2, 32'h100, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 8'h00);
    step("R9 misal stalled", 2'd2, 3'd0, 3'd2, 32'h102, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 8'h00);
    step("R9 IDLE excl",     2'd0, 3'd5, 3'd2, 32'h103, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R6 BUSY accepted", 2'd1, 3'd1, 3'd2, 32'h100, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h20);
    drain();

    // R7: alignment
    do_reset();
    step("R7 halfword ok",   2'd2, 3'd0, 3'd1, 32'h102, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h00);
    idle("R7 gap");
    step("R7 word misal",    2'd2, 3'd0, 3'd2, 32'h102, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h40);
    idle("R7 gap2");
    step("R7 dword misal",   2'd2, 3'd0, 3'd3, 32'h104, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h40);
    drain();

    // R8: overlapping exclusive phases
    do_reset();
    step("R8 mgr2 excl",     2'd2, 3'd0, 3'd2, 32'h100, 1'b1, 4'd2, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R8 mgr3 overlap",  2'd2, 3'd0, 3'd2, 32'h200, 1'b1, 4'd3, 1'b1, 1'b0, 1'b1, 8'h00);
    step("R8 mgr3 repeat",   2'd2, 3'd0, 3'd2, 32'h200, 1'b1, 4'd3, 1'b1, 1'b0, 1'b1, 8'h80);
    step("R8 plain after",   2'd2, 3'd0, 3'd2, 32'h300, 1'b0, 4'd3, 1'b1, 1'b0, 1'b1, 8'h00);
    drain();

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks_total - checks_failed, checks_total);
    $finish;
  end

endmodule